// File: doc/BRIEF.md
# Peripheral Clock Stop Controller

This block decides whether the peripheral clock reaches a small set of downstream units. It holds a 32-bit stop register. Each set bit withdraws the clock enable of one unit. Software sets stop bits by writing ones to the stop register. It clears them by writing ones to a separate write-only clear register at another address. Neither register needs a read-modify-write sequence.

Bit 1 of the stop register gates the clock enable of timer channels 3 and 4. Bit 0 gates the clock enable of the interrupt controller. While bit 0 is set, interrupt requests from the PCI controller and from timer channels 3 and 4 are not detected. Bits 31 to 2 are plain storage. The clock enables are modelled as synchronous enable outputs and not as gating cells.

The register interface is a synchronous bus. It carries a word address, a write strobe with write data, and a read strobe with registered read data.

Top module: `clk_stop_top`

## Requirements
- R1: After reset, every stop bit is 0, both clock enables are 1, interrupt detection is on, and a read of the stop register returns 0.
- R2: A write to the stop register (word address 0) sets every stop bit whose write-data bit is 1. Stop bits whose write-data bit is 0 keep their value.
- R3: A write to the clear register (word address 1) clears every stop bit whose write-data bit is 1. Stop bits whose write-data bit is 0 keep their value.
- R4: A read of the clear register returns 0, whatever the stop bits hold.
- R5: `tmrClkEn` equals the inverse of stop bit 1. It changes in the same clock edge that writes the bit.
- R6: `intcClkEn` equals the inverse of stop bit 0. It changes in the same clock edge that writes the bit.
- R7: Interrupt detection follows stop bit 0 one clock later. While detection is off, `irqReqOut` is all zeros. While detection is on, `irqReqOut` equals `irqReqIn` (bit 0 PCI controller, bit 1 timer channel 3, bit 2 timer channel 4).
- R8: A request that is present and then removed while detection is off never appears on `irqReqOut` once detection is turned back on.
- R9: Stop bits 31 to 2 are stored and read back, but they affect no clock enable and no interrupt output.
- R10: A write to any word address other than 0 or 1 changes no stop bit. A read of such an address returns 0.
- R11: Read data appears on `rdData` one clock after `rdEn` is sampled high. `rdData` is 0 in any cycle that follows a clock where `rdEn` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address of the register access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| irqReqIn | input | 3 | Raw requests: PCI controller, timer ch3, timer ch4 |
| tmrClkEn | output | 1 | Clock enable for timer channels 3 and 4 |
| intcClkEn | output | 1 | Clock enable for the interrupt controller |
| irqDetEn | output | 1 | Interrupt detection active |
| irqReqOut | output | 3 | Requests after the detection mask |

## Verification
The bench checks that a zero written to either register leaves the stop bits alone. A design that copied write data into the register would turn enables off or on behind software's back. It checks the clear register as read-only zero. A design that aliased it onto the stop register would leak the stop bits there. It checks that the detection mask lags the stop bit by exactly one clock, and that a request pulsed while detection was off is gone afterwards. A design that latched masked requests would raise a phantom interrupt when detection returns. Writes to unmapped addresses are checked by reading back the stop register. The upper stop bits are checked for having no effect on any output.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  // Stop-register bit positions that drive outputs
  localparam int INTC_BIT = 0;
  localparam int TMR_BIT  = 1;

  // Decoded access strobes from control to datapath
  typedef struct packed {
    logic setStb;
    logic clrStb;
    logic rdStop;
    logic rdClr;
  } busStb_t;
endpackage

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int STOP_OFS = 0,
  parameter int CLR_OFS  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output busStb_t           stb
);
  localparam logic [ADDR_W-1:0] STOP_A = ADDR_W'(STOP_OFS);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

  logic hitStop;
  logic hitClr;

  always_comb begin
    hitStop    = (addr == STOP_A);
    hitClr     = (addr == CLR_A);
    stb.setStb = wrEn & hitStop;
    stb.clrStb = wrEn & hitClr;
    stb.rdStop = rdEn & hitStop;
    stb.rdClr  = rdEn & hitClr;
  end
endmodule

// File: rtl/clk_stop_dp.sv
module clk_stop_dp
  import clk_stop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IRQ_W-1:0]  irqReqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              tmrClkEn,
  output logic              intcClkEn,
  output logic              irqDetEn,
  output logic [IRQ_W-1:0]  irqReqOut
);
  logic [DATA_W-1:0] stopReg;
  logic [DATA_W-1:0] stopNext;
  logic              detEnQ;

  // Per-bit set/clear cell; clear wins over set
  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    always_comb begin
      if (stb.clrStb && wrData[i])      stopNext[i] = 1'b0;
      else if (stb.setStb && wrData[i]) stopNext[i] = 1'b1;
      else                              stopNext[i] = stopReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopReg <= '0;
    else       stopReg <= stopNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdStop) rdData <= stopReg;
    else                 rdData <= '0;
  end

  // Registered detection mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) detEnQ <= 1'b1;
    else       detEnQ <= ~stopReg[INTC_BIT];
  end

  always_comb begin
    tmrClkEn  = ~stopReg[TMR_BIT];
    intcClkEn = ~stopReg[INTC_BIT];
    irqDetEn  = detEnQ;
    irqReqOut = irqReqIn & {IRQ_W{detEnQ}};
  end

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setStb && !stb.clrStb) |=> ((stopReg & $past(wrData)) == $past(wrData))); // R2
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |=> ((stopReg & $past(wrData)) == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.setStb && !stb.clrStb) |=> $stable(stopReg)); // R10
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdClr |=> (rdData == '0)); // R4
  AST_MASK_LAG: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopReg[INTC_BIT]) |-> (irqReqOut == '0)); // R7
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdStop || stb.rdClr) |=> (rdData == '0)); // R11
endmodule

// File: rtl/clk_stop_top.sv
module clk_stop_top
  import clk_stop_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IRQ_W    = 3,
  parameter int STOP_OFS = 0,
  parameter int CLR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [IRQ_W-1:0]  irqReqIn,
  output logic              tmrClkEn,
  output logic              intcClkEn,
  output logic              irqDetEn,
  output logic [IRQ_W-1:0]  irqReqOut
);
  busStb_t stb;

  clk_stop_ctrl #(
    .ADDR_W(ADDR_W), .STOP_OFS(STOP_OFS), .CLR_OFS(CLR_OFS)
  ) uCtrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  clk_stop_dp #(
    .DATA_W(DATA_W), .IRQ_W(IRQ_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .irqReqIn(irqReqIn), .rdData(rdData), .tmrClkEn(tmrClkEn),
    .intcClkEn(intcClkEn), .irqDetEn(irqDetEn), .irqReqOut(irqReqOut)
  );

  AST_NO_SET_AND_CLR: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setStb && stb.clrStb)); // R10
endmodule

// File: tb/tb_clk_stop_top.sv
module tb_clk_stop_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [2:0]  irqReqIn = '0;
  logic        tmrClkEn, intcClkEn, irqDetEn;
  logic [2:0]  irqReqOut;

  int errs = 0;
  int checks = 0;
  logic [31:0] model = '0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #4 clk = ~clk;

  clk_stop_top dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irqReqIn(irqReqIn), .tmrClkEn(tmrClkEn),
    .intcClkEn(intcClkEn), .irqDetEn(irqDetEn), .irqReqOut(irqReqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected value
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(req);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Monitor: pops expected values as read results appear
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        checks++; errs++;
        $display("FAIL R11: unexpected read result actual=%h expected=none", rdData);
      end else begin
        chk(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(8 * 100000);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    irqReqIn = 3'b111;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 tmrClkEn", {31'b0, tmrClkEn}, 32'd1);
    chk("R1 intcClkEn", {31'b0, intcClkEn}, 32'd1);
    chk("R1 irqDetEn", {31'b0, irqDetEn}, 32'd1);
    chk("R7 pass-through", {29'b0, irqReqOut}, 32'd7);
    chk("R11 idle rdData", rdData, 32'd0);
    rd(4'd0, 32'd0, "R1 stop read");

    // R5: set timer stop bit
    wr(4'd0, 32'h2); model |= 32'h2;
    chk("R5 tmrClkEn off", {31'b0, tmrClkEn}, 32'd0);
    chk("R6 intcClkEn still on", {31'b0, intcClkEn}, 32'd1);
    rd(4'd0, model, "R2 set bit1");

    // R2: zeros leave bits alone
    wr(4'd0, 32'h0);
    rd(4'd0, model, "R2 zero write");

    // R6/R7: stop interrupt controller plus upper bits
    wr(4'd0, 32'hF000_0001); model |= 32'hF000_0001;
    chk("R6 intcClkEn off", {31'b0, intcClkEn}, 32'd0);
    chk("R7 mask lags one clock", {29'b0, irqReqOut}, 32'd7);
    @(negedge clk);
    chk("R7 masked", {29'b0, irqReqOut}, 32'd0);
    chk("R7 irqDetEn off", {31'b0, irqDetEn}, 32'd0);
    rd(4'd1, 32'd0, "R4 clear reads zero");
    rd(4'd0, model, "R2 accumulate");

    // R8: pulse while masked, then unmask
    irqReqIn = 3'b000;
    @(negedge clk);
    irqReqIn = 3'b101;
    @(negedge clk);
    chk("R8 masked pulse", {29'b0, irqReqOut}, 32'd0);
    irqReqIn = 3'b000;
    wr(4'd1, 32'h1); model &= ~32'h1;
    chk("R6 intcClkEn on", {31'b0, intcClkEn}, 32'd1);
    @(negedge clk);
    chk("R8 no phantom", {29'b0, irqReqOut}, 32'd0);
    chk("R7 irqDetEn on", {31'b0, irqDetEn}, 32'd1);
    irqReqIn = 3'b010;
    #1;
    chk("R7 unmasked", {29'b0, irqReqOut}, 32'd2);

    // R3: clear semantics
    wr(4'd1, 32'h0);
    rd(4'd0, model, "R3 zero clear");
    wr(4'd1, 32'h1000_0002); model &= ~32'h1000_0002;
    chk("R5 tmrClkEn on", {31'b0, tmrClkEn}, 32'd1);
    rd(4'd0, model, "R3 partial clear");

    // R9: upper bits inert
    irqReqIn = 3'b111;
    @(negedge clk);
    chk("R9 tmrClkEn", {31'b0, tmrClkEn}, 32'd1);
    chk("R9 intcClkEn", {31'b0, intcClkEn}, 32'd1);
    chk("R9 irqReqOut", {29'b0, irqReqOut}, 32'd7);

    // R10: unmapped addresses
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    chk("R10 tmrClkEn", {31'b0, tmrClkEn}, 32'd1);
    rd(4'd0, model, "R10 stop unchanged");
    rd(4'd3, 32'd0, "R10 unmapped read");

    wr(4'd1, 32'hFFFF_FFFF); model = '0;
    rd(4'd0, model, "R3 clear all");
    repeat (2) @(negedge clk);
    chk("R11 idle rdData", rdData, 32'd0);
    chk("R11 queue drained", expQ.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule